// File: doc/BRIEF.md
# Dual-Channel Serial Converter Register Front End

This block is the digital side of a two-channel converter. A host writes 16-bit words over a three-wire serial link made of an active-low chip select, a serial clock and a data line. Each word carries a 2-bit channel-select field and a 14-bit code. When chip select rises, the code is written into the input register of every channel the field selects. A level-sensitive, active-low load strobe then copies both input registers into the output registers together, so both channels change on the same cycle.

All serial pins are sampled by a faster system clock through two-flop synchronizers, and edges are found by comparing successive synchronized samples. Two reset sources act on the channel registers: the system (power-on) reset and an asynchronous active-low preset pin. Both set every input and output register to zero-scale (0x0000) or mid-scale (0x2000), and a scale-select pin picks which. The two 14-bit output-register values are the block's outputs.

Top module: `dual_dac_if`

## Requirements
- R1: A serial word is 16 bits, most significant bit first. Bits 15:14 are the channel-select field and bits 13:0 are the code.
- R2: A bit is shifted in on each rising serial-clock edge only while chip select is low. Serial-clock edges while chip select is high leave the shift register unchanged.
- R3: When more than 16 bits arrive in one frame, only the last 16 are used at the chip-select rising edge.
- R4: On a chip-select rising edge the code goes to the input registers that the field selects: 00 selects none, 01 channel A, 10 channel B, 11 both.
- R5: While the load strobe is high, the output registers hold. While it is low, each output register follows its input register one system clock later.
- R6: A low level on the asynchronous preset pin forces all input and output registers to 0x0000 when scale select is 0, and to 0x2000 when it is 1.
- R7: The system reset presets input and output registers in the same way as R6 and clears the shift register to zero. The registers keep that value until a load.
- R8: With the load strobe held low, a chip-select rising edge reaches the channel outputs within 8 system clocks, with no separate strobe pulse.
- R9: A preset that overlaps a chip-select rising edge, or a low load strobe, wins. The registers stay at the preset value.
- R10: A chip-select rising edge after fewer than 16 bits, or after none, loads the shift register as it stands. Earlier bits fill the upper positions, and no bit count is checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| sysRstN | input | 1 | System / power-on reset, active low, asynchronous |
| presetN | input | 1 | Asynchronous preset pin, active low |
| midScale | input | 1 | Preset value select: 0 gives zero-scale, 1 gives mid-scale |
| csN | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data in |
| loadN | input | 1 | Level-sensitive load strobe, active low |
| dacA | output | 14 | Channel A output register |
| dacB | output | 14 | Channel B output register |

## Verification
All four channel-select values are swept against walking-one codes, plus all-zero and all-one codes. With the strobe held high, the sweep tells a wrong decode from a wrong bit order, and it also shows that a write does not leak through to the outputs before the strobe. The same codes are then sent with the strobe tied low to separate the transparent path from the buffered one. Frames that are too long, too short or empty, and clocks sent while chip select is idle, test the shift rule against a bench model of the shift register. A preset that overlaps a load and a strobe shows which one takes priority.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;
  localparam int CODE_W = 14;
  localparam int NCH    = 2;
  localparam int ADDR_W = NCH;
  localparam int WORD_W = CODE_W + ADDR_W;

  typedef struct packed {
    logic            shiftEn;
    logic            shiftBit;
    logic [NCH-1:0]  loadCh;
    logic            xferEn;
  } dacStrobe_t;
endpackage

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dual_dac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              loadN,
  input  logic [ADDR_W-1:0] addrBits,
  output dacStrobe_t        strobe
);
  localparam int PIN_N = 4;
  localparam logic [PIN_N-1:0] PIN_IDLE = 4'b1001;

  logic [SYNC_STAGES-1:0][PIN_N-1:0] pipe;
  logic [PIN_N-1:0] cur;
  logic csPrev, sclkPrev;
  logic csRise, sclkRise;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) pipe[0] <= PIN_IDLE;
    else          pipe[0] <= {csN, sclk, sdi, loadN};
  end

  for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_sync
    always_ff @(posedge clk or negedge sysRstN) begin
      if (!sysRstN) pipe[k] <= PIN_IDLE;
      else          pipe[k] <= pipe[k-1];
    end
  end

  assign cur = pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= cur[3];
      sclkPrev <= cur[2];
    end
  end

  assign csRise   = cur[3] & ~csPrev;
  assign sclkRise = cur[2] & ~sclkPrev & ~cur[3];

  always_comb begin
    strobe.shiftEn  = sclkRise;
    strobe.shiftBit = cur[1];
    strobe.loadCh   = csRise ? addrBits : '0;
    strobe.xferEn   = ~cur[0];
  end
endmodule

// File: rtl/dual_dac_path.sv
module dual_dac_path
  import dual_dac_pkg::*;
(
  input  logic                         clk,
  input  logic                         sysRstN,
  input  logic                         presetN,
  input  logic                         midScale,
  input  dacStrobe_t                   strobe,
  output logic [ADDR_W-1:0]            addrBits,
  output logic [NCH-1:0][CODE_W-1:0]   inCode,
  output logic [NCH-1:0][CODE_W-1:0]   dacCode
);
  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  logic [WORD_W-1:0] shiftReg;
  logic [CODE_W-1:0] presetVal;
  logic              regRstN;

  assign presetVal = midScale ? MID_CODE : '0;
  assign regRstN   = sysRstN & presetN;
  assign addrBits  = shiftReg[WORD_W-1 -: ADDR_W];

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)           shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], strobe.shiftBit};
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CODE_W-1:0] inQ, outQ;
    always_ff @(posedge clk or negedge regRstN) begin
      if (!regRstN) begin
        inQ  <= presetVal;
        outQ <= presetVal;
      end else begin
        if (strobe.loadCh[ch]) inQ  <= shiftReg[CODE_W-1:0];
        if (strobe.xferEn)     outQ <= inQ;
      end
    end
    assign inCode[ch]  = inQ;
    assign dacCode[ch] = outQ;
  end
endmodule

// File: rtl/dual_dac_if.sv
module dual_dac_if
  import dual_dac_pkg::*;
(
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              presetN,
  input  logic              midScale,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              loadN,
  output logic [CODE_W-1:0] dacA,
  output logic [CODE_W-1:0] dacB
);
  dacStrobe_t                 strobe;
  logic [ADDR_W-1:0]          addrBits;
  logic [NCH-1:0][CODE_W-1:0] inCode;
  logic [NCH-1:0][CODE_W-1:0] dacCode;

  dual_dac_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .sysRstN(sysRstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .loadN(loadN), .addrBits(addrBits), .strobe(strobe)
  );

  dual_dac_path u_path (
    .clk(clk), .sysRstN(sysRstN), .presetN(presetN), .midScale(midScale),
    .strobe(strobe), .addrBits(addrBits), .inCode(inCode), .dacCode(dacCode)
  );

  assign dacA = dacCode[0];
  assign dacB = dacCode[1];
endmodule

// File: rtl/dual_dac_chk.sv
module dual_dac_chk
  import dual_dac_pkg::*;
(
  input logic                       clk,
  input logic                       sysRstN,
  input logic                       presetN,
  input logic                       midScale,
  input dacStrobe_t                 strobe,
  input logic [NCH-1:0][CODE_W-1:0] inCode,
  input logic [NCH-1:0][CODE_W-1:0] dacCode
);
  logic [CODE_W-1:0] expPreset;
  assign expPreset = midScale ? (CODE_W'(1) << (CODE_W-1)) : '0;

  // R4
  no_select_hold_chk: assert property (@(posedge clk) disable iff (!(sysRstN && presetN))
    (strobe.loadCh == '0) |=> $stable(inCode));

  // R4
  both_select_equal_chk: assert property (@(posedge clk) disable iff (!(sysRstN && presetN))
    (strobe.loadCh == {NCH{1'b1}}) |=> (inCode[0] == inCode[1]));

  // R5
  strobe_high_hold_chk: assert property (@(posedge clk) disable iff (!(sysRstN && presetN))
    !strobe.xferEn |=> $stable(dacCode));

  // R5
  strobe_low_follow_chk: assert property (@(posedge clk) disable iff (!(sysRstN && presetN))
    strobe.xferEn |=> (dacCode == $past(inCode)));

  // R6
  preset_value_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    !presetN |-> (dacCode == {NCH{expPreset}}) && (inCode == {NCH{expPreset}}));
endmodule

bind dual_dac_if dual_dac_chk chk (
  .clk(clk), .sysRstN(sysRstN), .presetN(presetN), .midScale(midScale),
  .strobe(strobe), .inCode(inCode), .dacCode(dacCode)
);

// File: tb/dual_dac_if_test.sv
module dual_dac_if_test;
  import dual_dac_pkg::*;

  logic clk = 0;
  logic sysRstN = 0, presetN = 1, midScale = 0;
  logic csN = 1, sclk = 0, sdi = 0, loadN = 1;
  logic [CODE_W-1:0] dacA, dacB;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [15:0] shiftM = 0;
  logic [13:0] inA = 0, inB = 0, expA = 0, expB = 0;

  always #2 clk = ~clk;

  dual_dac_if uut (
    .clk(clk), .sysRstN(sysRstN), .presetN(presetN), .midScale(midScale),
    .csN(csN), .sclk(sclk), .sdi(sdi), .loadN(loadN), .dacA(dacA), .dacB(dacB)
  );

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [13:0] act, logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkBoth(string req);
    chk({req, " chA"}, dacA, expA);
    chk({req, " chB"}, dacB, expB);
  endtask

  function automatic logic [13:0] pv(logic m);
    return m ? 14'h2000 : 14'h0000;
  endfunction

  task automatic pulseClk(logic b);
    sdi = b; waitc(3);
    sclk = 1; waitc(3);
    sclk = 0;
    if (!csN) shiftM = {shiftM[14:0], b};
  endtask

  task automatic modelLoad();
    if (presetN) begin
      if (shiftM[14]) inA = shiftM[13:0];
      if (shiftM[15]) inB = shiftM[13:0];
      if (!loadN) begin expA = inA; expB = inB; end
    end
  endtask

  task automatic frame(logic [31:0] w, int n);
    csN = 0; waitc(3);
    for (int i = n - 1; i >= 0; i--) pulseClk(w[i]);
    waitc(3);
    csN = 1;
    modelLoad();
    waitc(8);
  endtask

  task automatic strobePulse();
    loadN = 0; waitc(8);
    loadN = 1; waitc(8);
    expA = inA; expB = inB;
  endtask

  task automatic sysReset(logic m);
    midScale = m; sysRstN = 0; waitc(4);
    sysRstN = 1; waitc(4);
    inA = pv(m); inB = pv(m); expA = inA; expB = inB; shiftM = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R7 power-on reset, zero-scale
    waitc(4);
    sysRstN = 1; waitc(4);
    chkBoth("R7 zero-scale reset");
    // R7 mid-scale reset
    sysReset(1);
    chkBoth("R7 mid-scale reset");
    sysReset(0);

    // R1 R4 R5 channel-select x code sweep with buffered loading
    for (int a = 0; a < 4; a++) begin
      for (int c = 0; c < 16; c++) begin
        logic [13:0] code;
        code = (c < 14) ? (14'h1 << c) : ((c == 14) ? 14'h0000 : 14'h3FFF);
        code = code ^ 14'(a * 14'h0111);
        frame({16'h0, 2'(a), code}, 16);
        chkBoth("R5 hold before strobe");
        strobePulse();
        chkBoth("R4 R1 decode after strobe");
      end
    end

    // R8 strobe tied low, direct update
    loadN = 0; waitc(8);
    expA = inA; expB = inB;
    for (int c = 0; c < 14; c++) begin
      frame({16'h0, 2'(c % 4), 14'h3FFF ^ (14'h1 << c)}, 16);
      chkBoth("R8 transparent update");
    end
    loadN = 1; waitc(8);

    // R3 over-long frame: last 16 bits used
    frame(32'h000F_9ABC ^ 32'h000A_0000, 20);
    strobePulse();
    chkBoth("R3 last 16 bits");

    // R10 short frame: 8 bits shift into the existing contents
    frame(32'h0000_0077, 8);
    strobePulse();
    chkBoth("R10 short frame");

    // R2 clocks while chip select is high are ignored, then empty frame loads
    for (int i = 0; i < 5; i++) pulseClk(1'b1);
    frame(32'h0, 0);
    strobePulse();
    chkBoth("R2 idle clocks ignored");

    // R6 asynchronous preset, both scales
    midScale = 1; waitc(2);
    presetN = 0; waitc(3);
    presetN = 1; waitc(3);
    inA = 14'h2000; inB = 14'h2000; expA = inA; expB = inB;
    chkBoth("R6 mid-scale preset");
    midScale = 0; waitc(2);
    presetN = 0; waitc(3);
    presetN = 1; waitc(3);
    inA = 0; inB = 0; expA = 0; expB = 0;
    chkBoth("R6 zero-scale preset");

    // R9 preset overlapping a load and a low strobe
    midScale = 1; waitc(2);
    loadN = 0;
    csN = 0; waitc(3);
    for (int i = 15; i >= 0; i--) pulseClk(16'hC5A5 >> i);
    waitc(3);
    presetN = 0; waitc(2);
    csN = 1; waitc(8);
    presetN = 1; waitc(8);
    inA = 14'h2000; inB = 14'h2000; expA = inA; expB = inB;
    chkBoth("R9 preset wins");
    loadN = 1; waitc(8);
    // R10 empty frame reloads shift contents left by the overlapped frame
    frame(32'h0, 0);
    strobePulse();
    chkBoth("R10 empty frame reload");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule